// File: doc/BRIEF.md
# Bit-Depth Expanding Unpacker

The unit reads a stream of packed bytes, splits each byte into narrow source elements, widens every element to a larger destination width and packs the widened results into 32-bit words. Each element can be raised by a programmable offset before it is packed. A one-cycle start pulse latches a job configuration: the number of source bytes, the source and destination width codes, and a 32-bit word whose low 31 bits are the offset and whose top bit also applies the offset to zero elements.

Bytes enter through a valid/ready handshake, and finished words leave through another one. The end of a job is marked by a single-cycle done pulse. The controller is a five-state machine. IDLE waits for start. It moves to FETCH, or straight to FINISH when the byte count is zero. FETCH takes one byte and moves to EXPAND. EXPAND handles one element per cycle. From EXPAND the machine goes to EMIT when the accumulator fills, to FETCH or FINISH when the byte runs out, and otherwise stays in EXPAND. EMIT holds a full word until it is accepted, then returns to EXPAND, FETCH or FINISH. FINISH raises done and returns to IDLE.

Top module: `bit_widen_unpack`

## Requirements
- R1: Source width code s (0..3) selects 1, 2, 4 or 8 bits per element (1 shifted left by s). Destination width code d (0..5) selects 1 shifted left by d bits. Codes 6 and 7 act as 32 bits.
- R2: The elements of a byte are taken from the least significant end upward.
- R3: A non-zero element gets offset bits 30:0 added. A zero element gets the offset only when offset bit 31 is set, and otherwise stays zero.
- R4: Widened elements fill the word from bit 0 upward. Each element advances the fill position by the destination width. A word that reaches 32 bits is presented on the output.
- R5: A widened value is not masked to the destination width. Its excess bits are ORed into the higher positions of the same word, and bits beyond bit 31 are lost.
- R6: A job ends after exactly the configured number of bytes has been consumed. It then raises done for one cycle and returns to idle. A byte count of zero gives done with no words.
- R7: Bits left in a partly filled word at the end of a job are never emitted. The next job starts with an empty word.
- R8: Start latches the configuration only when idle. A start pulse during a job has no effect on that job's output.
- R9: in_ready is low whenever out_valid is high. A word that is not accepted holds its value until it is accepted.
- R10: After reset the unit is idle, with in_ready, out_valid, done and busy all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, latches configuration when idle |
| cfg_bytes_i | input | CNT_W | Number of source bytes in the job |
| cfg_src_i | input | 2 | Source element width code |
| cfg_dst_i | input | 3 | Destination element width code |
| cfg_off_i | input | WORD_W | Offset in bits 30:0, zero-add flag in bit 31 |
| in_valid_i | input | 1 | Source byte valid |
| in_data_i | input | 8 | Source byte |
| in_ready_o | output | 1 | Unit accepts a byte |
| out_valid_o | output | 1 | Packed word valid |
| out_data_o | output | WORD_W | Packed word |
| out_ready_i | input | 1 | Consumer accepts the word |
| done_o | output | 1 | One-cycle end-of-job pulse |
| busy_o | output | 1 | Job in progress |

## Verification
The bench compares every job against a bench-side model of the packing rules. It targets the cases that are easy to get wrong. Offset overflow must spill into neighbouring slots; a masking design would lose those bits. The zero-add flag must be honoured; a design that ignores it would leave zeros where offset values belong. A leftover partial word must be dropped and cleared; a leaky design would emit it or mix it into the next job. A zero byte count must finish without hanging. A start pulse in the middle of a job must be ignored; a design that relatched would change widths partway through. Under output backpressure, input must stall and the held word must stay unchanged; a design that keeps fetching would overwrite the pending word.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXPAND,
        ST_EMIT,
        ST_FINISH
    } unpk_state_e;

    // Source element width in bits from its 2-bit code.
    function automatic int src_bits(input logic [1:0] code);
        return 1 << code;
    endfunction

    // Destination element width in bits; codes above 5 saturate at 32.
    function automatic int dst_bits(input logic [2:0] code);
        return (code >= 3'd5) ? 32 : (1 << code);
    endfunction

endpackage

// File: rtl/unpk_elem_slice.sv
module unpk_elem_slice
    import unpk_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [7:0]        byte_i,
    input  logic [1:0]        src_code_i,
    input  logic [2:0]        idx_i,
    input  logic [WORD_W-2:0] offset_i,
    input  logic              zero_add_i,
    output logic [WORD_W-1:0] elem_o
);
    localparam int N_CODES = 4;

    logic [7:0] mask_tab [N_CODES];
    logic [2:0] shamt;
    logic [7:0] shifted;
    logic [7:0] raw;
    logic       bump;

    // One mask per source width code.
    for (genvar g = 0; g < N_CODES; g++) begin : g_mask
        assign mask_tab[g] = 8'((1 << (1 << g)) - 1);
    end

    always_comb begin
        shamt   = 3'(idx_i << src_code_i);
        shifted = byte_i >> shamt;
        raw     = shifted & mask_tab[src_code_i];
        bump    = (raw != 8'd0) || zero_add_i;
        elem_o  = bump ? (WORD_W'(raw) + WORD_W'(offset_i)) : WORD_W'(raw);
    end

endmodule

// File: rtl/unpk_accum.sv
module unpk_accum #(
    parameter int WORD_W = 32,
    parameter int FILL_W = $clog2(WORD_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              ins_i,
    input  logic [FILL_W-1:0] step_i,
    input  logic [WORD_W-1:0] elem_i,
    output logic [WORD_W-1:0] word_o,
    output logic              will_fill_o
);
    localparam logic [FILL_W:0] FULL = (FILL_W+1)'(WORD_W);

    logic [WORD_W-1:0] acc_q;
    logic [FILL_W-1:0] fill_q;
    logic [FILL_W:0]   fill_sum;

    always_comb begin
        fill_sum    = {1'b0, fill_q} + {1'b0, step_i};
        will_fill_o = (fill_sum >= FULL);
        word_o      = acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            fill_q <= '0;
        end else if (clear_i) begin
            acc_q  <= '0;
            fill_q <= '0;
        end else if (ins_i) begin
            acc_q  <= acc_q | (elem_i << fill_q);
            fill_q <= will_fill_o ? FILL_W'(WORD_W) : fill_sum[FILL_W-1:0];
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_W'(WORD_W)); // R4
    AST_NO_INS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ins_i |-> (fill_q < FILL_W'(WORD_W))); // R4

endmodule

// File: rtl/unpk_ctrl.sv
module unpk_ctrl
    import unpk_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  cfg_bytes_i,
    input  logic [1:0]        cfg_src_i,
    input  logic [2:0]        cfg_dst_i,
    input  logic [WORD_W-1:0] cfg_off_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_data_i,
    input  logic              out_ready_i,
    input  logic              will_fill_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              ins_o,
    output logic              acc_clear_o,
    output logic [7:0]        byte_o,
    output logic [2:0]        idx_o,
    output logic [1:0]        src_code_o,
    output logic [2:0]        dst_code_o,
    output logic [WORD_W-2:0] offset_o,
    output logic              zero_add_o
);
    unpk_state_e       state_q, state_n;
    logic [CNT_W-1:0]  bytes_left_q;
    logic [2:0]        idx_q;
    logic [7:0]        byte_q;
    logic              pend_q;
    logic [1:0]        src_q;
    logic [2:0]        dst_q;
    logic [WORD_W-1:0] off_q;
    logic [2:0]        last_idx;
    logic              last_elem;

    always_comb begin
        last_idx  = 3'((4'd8 >> src_q) - 4'd1);
        last_elem = (idx_q == last_idx);
    end

    // Next-state decision.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i)
                    state_n = (cfg_bytes_i == '0) ? ST_FINISH : ST_FETCH;
            end
            ST_FETCH: begin
                if (in_valid_i) state_n = ST_EXPAND;
            end
            ST_EXPAND: begin
                if (will_fill_i)
                    state_n = ST_EMIT;
                else if (last_elem)
                    state_n = (bytes_left_q == CNT_W'(1)) ? ST_FINISH : ST_FETCH;
            end
            ST_EMIT: begin
                if (out_ready_i) begin
                    if (pend_q)
                        state_n = ST_EXPAND;
                    else
                        state_n = (bytes_left_q == '0) ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Job configuration and per-byte counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_left_q <= '0;
            idx_q        <= '0;
            byte_q       <= '0;
            pend_q       <= 1'b0;
            src_q        <= '0;
            dst_q        <= '0;
            off_q        <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        bytes_left_q <= cfg_bytes_i;
                        src_q        <= cfg_src_i;
                        dst_q        <= cfg_dst_i;
                        off_q        <= cfg_off_i;
                        idx_q        <= '0;
                        pend_q       <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (in_valid_i) begin
                        byte_q <= in_data_i;
                        idx_q  <= '0;
                    end
                end
                ST_EXPAND: begin
                    pend_q <= !last_elem;
                    if (last_elem) begin
                        idx_q        <= '0;
                        bytes_left_q <= bytes_left_q - CNT_W'(1);
                    end else begin
                        idx_q <= idx_q + 3'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        in_ready_o  = 1'b0;
        out_valid_o = 1'b0;
        done_o      = 1'b0;
        ins_o       = 1'b0;
        acc_clear_o = 1'b0;
        busy_o      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o      = 1'b0;
                acc_clear_o = start_i;
            end
            ST_FETCH:  in_ready_o = 1'b1;
            ST_EXPAND: ins_o = 1'b1;
            ST_EMIT: begin
                out_valid_o = 1'b1;
                acc_clear_o = out_ready_i;
            end
            ST_FINISH: done_o = 1'b1;
            default: ;
        endcase
        byte_o     = byte_q;
        idx_o      = idx_q;
        src_code_o = src_q;
        dst_code_o = dst_q;
        offset_o   = off_q[WORD_W-2:0];
        zero_add_o = off_q[WORD_W-1];
    end

    AST_NO_IN_DURING_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid_o && in_ready_o)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(src_q) && $stable(dst_q) && $stable(off_q))); // R8
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (bytes_left_q <= $past(bytes_left_q))); // R6

endmodule

// File: rtl/bit_widen_unpack.sv
module bit_widen_unpack
    import unpk_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  cfg_bytes_i,
    input  logic [1:0]        cfg_src_i,
    input  logic [2:0]        cfg_dst_i,
    input  logic [WORD_W-1:0] cfg_off_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_data_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] out_data_o,
    input  logic              out_ready_i,
    output logic              done_o,
    output logic              busy_o
);
    localparam int FILL_W = $clog2(WORD_W) + 1;

    logic              ins;
    logic              acc_clear;
    logic              will_fill;
    logic [7:0]        cur_byte;
    logic [2:0]        cur_idx;
    logic [1:0]        src_code;
    logic [2:0]        dst_code;
    logic [WORD_W-2:0] offset;
    logic              zero_add;
    logic [WORD_W-1:0] elem;
    logic [FILL_W-1:0] step;

    assign step = FILL_W'(dst_bits(dst_code));

    unpk_ctrl #(.CNT_W(CNT_W), .WORD_W(WORD_W)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .cfg_bytes_i (cfg_bytes_i),
        .cfg_src_i   (cfg_src_i),
        .cfg_dst_i   (cfg_dst_i),
        .cfg_off_i   (cfg_off_i),
        .in_valid_i  (in_valid_i),
        .in_data_i   (in_data_i),
        .out_ready_i (out_ready_i),
        .will_fill_i (will_fill),
        .in_ready_o  (in_ready_o),
        .out_valid_o (out_valid_o),
        .done_o      (done_o),
        .busy_o      (busy_o),
        .ins_o       (ins),
        .acc_clear_o (acc_clear),
        .byte_o      (cur_byte),
        .idx_o       (cur_idx),
        .src_code_o  (src_code),
        .dst_code_o  (dst_code),
        .offset_o    (offset),
        .zero_add_o  (zero_add)
    );

    unpk_elem_slice #(.WORD_W(WORD_W)) i_slice (
        .byte_i     (cur_byte),
        .src_code_i (src_code),
        .idx_i      (cur_idx),
        .offset_i   (offset),
        .zero_add_i (zero_add),
        .elem_o     (elem)
    );

    unpk_accum #(.WORD_W(WORD_W), .FILL_W(FILL_W)) i_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (acc_clear),
        .ins_i       (ins),
        .step_i      (step),
        .elem_i      (elem),
        .word_o      (out_data_o),
        .will_fill_o (will_fill)
    );

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R9

endmodule

// File: tb/test_bit_widen_unpack.sv
module test_bit_widen_unpack;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] cfg_bytes_i = '0;
    logic [1:0]  cfg_src_i = '0;
    logic [2:0]  cfg_dst_i = '0;
    logic [31:0] cfg_off_i = '0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_data_i = '0;
    logic        in_ready_o;
    logic        out_valid_o;
    logic [31:0] out_data_o;
    logic        out_ready_i = 1'b1;
    logic        done_o;
    logic        busy_o;

    int tests = 0;
    int fails = 0;

    logic [7:0]  src_q [$];
    logic [31:0] exp_q [$];
    logic [31:0] got_q [$];
    bit          collect = 0;
    bit          ready_slow = 0;
    int          done_cnt = 0;
    int          overlap = 0;
    int          hold_err = 0;
    int          cyc = 0;
    logic        prev_stall = 0;
    logic [31:0] prev_word = '0;

    always #(CLK_P/2) clk = ~clk;

    bit_widen_unpack i_bit_widen_unpack (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_bytes_i(cfg_bytes_i),
        .cfg_src_i(cfg_src_i), .cfg_dst_i(cfg_dst_i), .cfg_off_i(cfg_off_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i),
        .done_o(done_o), .busy_o(busy_o)
    );

    // Output monitor: drives ready and records accepted words between edges.
    always @(negedge clk) begin
        cyc++;
        out_ready_i = ready_slow ? (cyc % 3 == 2) : 1'b1;
        if (collect) begin
            if (prev_stall && !(out_valid_o && out_data_o == prev_word)) hold_err++;
            if (out_valid_o && out_ready_i) got_q.push_back(out_data_o);
            if (out_valid_o && in_ready_o) overlap++;
            if (done_o) done_cnt++;
        end
        prev_stall = out_valid_o && !out_ready_i;
        prev_word  = out_data_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [1:0] sc, input logic [2:0] dc, input logic [31:0] off);
        int sw = 1 << sc;
        int dw = (dc >= 3'd5) ? 32 : (1 << dc);
        logic [63:0] acc = '0;
        int fill = 0;
        exp_q.delete();
        foreach (src_q[k]) begin
            for (int i = 0; i < 8 / sw; i++) begin
                int e = int'((src_q[k] >> (i * sw))) & ((1 << sw) - 1);
                logic [63:0] v = 64'(e);
                if (e != 0 || off[31]) v = 64'(e) + 64'(off[30:0]);
                acc = acc | ((v << fill) & 64'hFFFF_FFFF);
                fill += dw;
                if (fill >= 32) begin
                    exp_q.push_back(acc[31:0]);
                    acc = '0;
                    fill = 0;
                end
            end
        end
    endfunction

    task automatic run_case(input string req, input logic [1:0] sc, input logic [2:0] dc,
                            input logic [31:0] off, input bit slow, input bit poke);
        int w = 0;
        model(sc, dc, off);
        got_q.delete();
        done_cnt = 0; overlap = 0; hold_err = 0;
        ready_slow = slow;
        collect = 1;
        @(negedge clk);
        cfg_bytes_i = 16'(src_q.size());
        cfg_src_i = sc; cfg_dst_i = dc; cfg_off_i = off;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        foreach (src_q[k]) begin
            if (poke && k == 1) begin
                start_i = 1'b1;
                cfg_bytes_i = 16'd3; cfg_src_i = 2'd3; cfg_dst_i = 3'd0;
                cfg_off_i = 32'hFFFF_FFFF;
                @(negedge clk);
                start_i = 1'b0;
            end
            in_valid_i = 1'b1;
            in_data_i = src_q[k];
            while (!in_ready_o) @(negedge clk);
            @(negedge clk);
        end
        in_valid_i = 1'b0;
        while (done_cnt == 0 && w < 5000) begin
            @(negedge clk);
            w++;
        end
        repeat (3) @(negedge clk);
        collect = 0;
        ready_slow = 0;
        chk({req, " word count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            chk({req, " word"}, got_q[i], exp_q[i]);
        chk({req, " R6 done pulses"}, done_cnt, 1);
        chk({req, " R9 in_ready during out_valid"}, overlap, 0);
        chk({req, " R9 held word"}, hold_err, 0);
        chk({req, " R6 idle after job"}, busy_o, 1'b0);
    endtask

    task automatic t_reset;
        chk("R10 in_ready", in_ready_o, 1'b0);
        chk("R10 out_valid", out_valid_o, 1'b0);
        chk("R10 done", done_o, 1'b0);
        chk("R10 busy", busy_o, 1'b0);
    endtask

    task automatic t_basic;   // R1 R2 R4: 1-bit to 4-bit
        src_q = '{8'hA5, 8'h3C, 8'hFF, 8'h00};
        run_case("R2 R4 1to4", 2'd0, 3'd2, 32'h0000_0001, 0, 0);
    endtask

    task automatic t_pass;    // R2: 1-bit to 1-bit, offset 0, bytes pass unchanged
        src_q = '{8'h12, 8'h34, 8'h56, 8'h78};
        run_case("R2 1to1", 2'd0, 3'd0, 32'h0, 0, 0);
        tests++;
        if (got_q.size() != 1 || got_q[0] !== 32'h7856_3412) begin
            fails++;
            $display("FAIL R2 pass-through actual=%h expected=%h",
                     (got_q.size() > 0) ? got_q[0] : 32'hx, 32'h7856_3412);
        end
    endtask

    task automatic t_zero_flag; // R3
        src_q = '{8'h1B, 8'hE4};
        run_case("R3 no zero-add", 2'd1, 3'd3, 32'h0000_0005, 0, 0);
        run_case("R3 zero-add", 2'd1, 3'd3, 32'h8000_0005, 0, 0);
    endtask

    task automatic t_overflow; // R5
        src_q = '{8'h21, 8'h43};
        run_case("R5 spill", 2'd2, 3'd4, 32'h0001_FFF0, 0, 0);
    endtask

    task automatic t_wide;     // R1: 8 to 32, and code 7 treated as 32
        src_q = '{8'h00, 8'h01, 8'h80};
        run_case("R1 8to32", 2'd3, 3'd5, 32'h7FFF_FF00, 0, 0);
        src_q = '{8'h9C};
        run_case("R1 code7", 2'd2, 3'd7, 32'h0000_0100, 0, 0);
    endtask

    task automatic t_partial;  // R7
        src_q = '{8'hEE};
        run_case("R7 partial dropped", 2'd3, 3'd4, 32'h0, 0, 0);
        src_q = '{8'h11, 8'h22};
        run_case("R7 fresh word", 2'd3, 3'd4, 32'h0, 0, 0);
    endtask

    task automatic t_empty;    // R6
        src_q.delete();
        run_case("R6 zero bytes", 2'd0, 3'd3, 32'h0, 0, 0);
    endtask

    task automatic t_backpressure; // R9
        src_q = '{8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB, 8'hCD, 8'hEF};
        run_case("R9 slow sink", 2'd0, 3'd1, 32'h0000_0002, 1, 0);
    endtask

    task automatic t_start_busy; // R8
        src_q = '{8'hC3, 8'h5A, 8'h0F, 8'hF0};
        run_case("R8 start ignored", 2'd1, 3'd2, 32'h0000_0003, 0, 1);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_pass();
        t_zero_flag();
        t_overflow();
        t_wide();
        t_partial();
        t_empty();
        t_backpressure();
        t_start_busy();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule